// File: doc/BRIEF.md
# Flash Command Sequencer

This block is a cycle-based behavioural controller for a parallel NOR-style flash store. A host talks to it over a plain synchronous bus: chip enable, write enable, output enable, an 11-bit word address and 16-bit data. Unlock-guarded write sequences start programming or erasing of a small internal word array. While an operation runs, reads return a status word instead of array contents, and a ready output stays low.

Other features are an unlock-bypass mode that cuts programming to two writes and erase of the whole array or of several sectors. An erase can be frozen so that the host can read or program sectors outside it. A lock input protects sectors one at a time. The sector layout follows a 2:1:1:4 boot group followed by NBIG equal large sectors, all scaled by UNIT words. Operation lengths are cycle-count parameters.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A write is any clock edge with ce_n and we_n low. Reads need ce_n and oe_n low and we_n high, and rdata shows the result on the following edge. Four writes program a word: 0x00AA to address 0x555, 0x0055 to 0x2AA, 0x00A0 to 0x555, then the data to the target address. The word reads back PROG_CYC cycles later. Commands are decoded from wdata[7:0].
- R2: Any write that does not fit the expected step of a sequence ends that sequence without effect, and so does the reset command 0xF0. Later writes must start a new sequence from the first unlock step.
- R3: Programming only clears bits: the stored word becomes the old word AND the written data.
- R4: Three unlock-style writes with 0x80, then 0x00AA to 0x555 and 0x0055 to 0x2AA, lead to the erase choice. 0x10 to 0x555 erases the whole array. 0x30 to an address in a sector erases that sector, and each further 0x30 write within WIN_CYC cycles adds another sector. Erased words read 0xFFFF and unselected sectors keep their data.
- R5: A read during programming returns a status word with bit 7 equal to the inverse of bit 7 of the data being written. A read during erase returns a status word with bit 7 equal to 0. Bit 6 holds a toggle that starts at 0 after reset and inverts after every such read. All other bits are 0. A read of a suspended sector returns bit 7 = 1 with the toggle shown but left unchanged.
- R6: The unlock writes followed by 0x20 to 0x555 enter bypass. In bypass, 0xA0 to any address followed by address/data programs a word. 0x90 then 0x00 leaves bypass.
- R7: 0xB0 during the erase phase suspends it. Sectors outside the erase read array data and can be programmed. 0x30 resumes the remaining erase time.
- R8: While lock[s] is 1, program and erase leave every word of sector s unchanged.
- R9: ready_n is 0 while programming, while gathering sectors and while erasing. It is 1 otherwise, including while suspended.
- R10: A synchronous high rst returns the block to array read, aborts any running operation without altering the array, and clears bypass, suspend and the toggle. After reset, rdata is 0 and ready_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe, active low |
| addr | input | 11 | Word address |
| wdata | input | 16 | Write data / command byte |
| lock | input | NSEC | Per-sector protection, 1 = protected |
| rdata | output | 16 | Registered read data or status word |
| ready_n | output | 1 | Low while an operation is running |

## Verification
The hardest state to reach is a suspended sector erase with a program nested inside it. To get there, the host must finish a sector erase sequence, let the sector-gathering window run out, and only then issue the suspend command. The stimulus does this by counting idle cycles past WIN_CYC before it writes 0xB0. In that state it reads an unaffected sector, reads the frozen sector twice to see that the toggle stays still, programs a word elsewhere, and resumes. A final read shows that the erase went on to complete.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;

    localparam logic [10:0] UL_ADDR_A = 11'h555;
    localparam logic [10:0] UL_ADDR_B = 11'h2AA;

    localparam logic [7:0] C_UNLOCK_A = 8'hAA;
    localparam logic [7:0] C_UNLOCK_B = 8'h55;
    localparam logic [7:0] C_PROG     = 8'hA0;
    localparam logic [7:0] C_ERS_SET  = 8'h80;
    localparam logic [7:0] C_ERS_ALL  = 8'h10;
    localparam logic [7:0] C_ERS_SEC  = 8'h30;
    localparam logic [7:0] C_BYP_ON   = 8'h20;
    localparam logic [7:0] C_SUSPEND  = 8'hB0;
    localparam logic [7:0] C_RESUME   = 8'h30;
    localparam logic [7:0] C_BYP_OFF1 = 8'h90;
    localparam logic [7:0] C_BYP_OFF2 = 8'h00;

    typedef enum logic [3:0] {
        ST_HOME, ST_UL1, ST_UL2, ST_PSET, ST_ESET, ST_EUL1, ST_EUL2,
        ST_EWIN, ST_PROG, ST_ERASE, ST_BEXIT
    } seq_st_e;

    typedef struct packed {
        logic        wr;
        logic [10:0] addr;
        logic [15:0] data;
    } bus_wr_t;

    // Sector index of a word: boot group 2U,U,U,4U then big sectors of 8U.
    function automatic int sec_of(int a, int unit, int nbig);
        int s;
        if (a < 2*unit)      s = 0;
        else if (a < 3*unit) s = 1;
        else if (a < 4*unit) s = 2;
        else if (a < 8*unit) s = 3;
        else                 s = 4 + (a - 8*unit) / (8*unit);
        if (s > 3 + nbig) s = 3 + nbig;
        return s;
    endfunction

    function automatic logic [15:0] stat_word(logic b7, logic b6);
        return {8'h00, b7, b6, 6'h00};
    endfunction

endpackage

// File: rtl/fcmd_seq.sv
`timescale 1ns/1ps
module fcmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int UNIT      = 2,
    parameter int NBIG      = 3,
    parameter int PROG_CYC  = 4,
    parameter int ERASE_CYC = 20,
    parameter int WIN_CYC   = 6,
    localparam int NSEC  = 4 + NBIG,
    localparam int WORDS = UNIT * (8 + 8 * NBIG),
    localparam int AW    = $clog2(WORDS),
    localparam int SW    = $clog2(NSEC)
) (
    input  logic            clk,
    input  logic            rst,
    input  bus_wr_t         bw,
    output logic            prog_fire,
    output logic [AW-1:0]   prog_addr,
    output logic [15:0]     prog_data,
    output logic            erase_fire,
    output logic [NSEC-1:0] marks,
    output logic            prog_busy,
    output logic            erase_busy,
    output logic            susp
);
    localparam int PCW = $clog2(PROG_CYC + 1);
    localparam int ECW = $clog2(ERASE_CYC + 1);
    localparam int WCW = $clog2(WIN_CYC + 1);

    seq_st_e        st;
    logic           byp;
    logic [PCW-1:0] pcnt;
    logic [ECW-1:0] ecnt;
    logic [WCW-1:0] wcnt;
    logic [7:0]     cmd;
    logic [SW-1:0]  wr_sec;
    logic           at_a, at_b, do_susp;

    assign cmd     = bw.data[7:0];
    assign at_a    = (bw.addr == UL_ADDR_A);
    assign at_b    = (bw.addr == UL_ADDR_B);
    assign wr_sec  = SW'(sec_of(int'(bw.addr[AW-1:0]), UNIT, NBIG));
    assign do_susp = bw.wr && (cmd == C_SUSPEND);

    assign prog_busy  = (st == ST_PROG);
    assign erase_busy = (st == ST_EWIN) || (st == ST_ERASE);
    assign prog_fire  = prog_busy && (pcnt == PCW'(1));
    assign erase_fire = (st == ST_ERASE) && (ecnt == ECW'(1)) && !do_susp;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_HOME;
            byp       <= 1'b0;
            susp      <= 1'b0;
            marks     <= '0;
            pcnt      <= '0;
            ecnt      <= '0;
            wcnt      <= '0;
            prog_addr <= '0;
            prog_data <= '0;
        end else begin
            case (st)
                ST_HOME: if (bw.wr) begin
                    if (susp && cmd == C_RESUME) begin
                        susp <= 1'b0;
                        st   <= ST_ERASE;
                    end else if (byp) begin
                        if (cmd == C_PROG)          st <= ST_PSET;
                        else if (cmd == C_BYP_OFF1) st <= ST_BEXIT;
                    end else if (at_a && cmd == C_UNLOCK_A) begin
                        st <= ST_UL1;
                    end
                end
                ST_UL1: if (bw.wr)
                    st <= (at_b && cmd == C_UNLOCK_B) ? ST_UL2 : ST_HOME;
                ST_UL2: if (bw.wr) begin
                    st <= ST_HOME;
                    if (at_a && cmd == C_PROG)                  st <= ST_PSET;
                    else if (at_a && cmd == C_ERS_SET && !susp) st <= ST_ESET;
                    else if (at_a && cmd == C_BYP_ON && !susp)  byp <= 1'b1;
                end
                ST_PSET: if (bw.wr) begin
                    if (susp && marks[wr_sec]) begin
                        st <= ST_HOME;
                    end else begin
                        prog_addr <= bw.addr[AW-1:0];
                        prog_data <= bw.data;
                        pcnt      <= PCW'(PROG_CYC);
                        st        <= ST_PROG;
                    end
                end
                ST_PROG: begin
                    pcnt <= pcnt - PCW'(1);
                    if (pcnt == PCW'(1)) st <= ST_HOME;
                end
                ST_ESET: if (bw.wr)
                    st <= (at_a && cmd == C_UNLOCK_A) ? ST_EUL1 : ST_HOME;
                ST_EUL1: if (bw.wr)
                    st <= (at_b && cmd == C_UNLOCK_B) ? ST_EUL2 : ST_HOME;
                ST_EUL2: if (bw.wr) begin
                    if (at_a && cmd == C_ERS_ALL) begin
                        marks <= '1;
                        ecnt  <= ECW'(ERASE_CYC);
                        st    <= ST_ERASE;
                    end else if (cmd == C_ERS_SEC) begin
                        marks[wr_sec] <= 1'b1;
                        wcnt          <= WCW'(WIN_CYC);
                        st            <= ST_EWIN;
                    end else begin
                        st <= ST_HOME;
                    end
                end
                ST_EWIN: begin
                    if (bw.wr && cmd == C_ERS_SEC) marks[wr_sec] <= 1'b1;
                    wcnt <= wcnt - WCW'(1);
                    if (wcnt == WCW'(1)) begin
                        ecnt <= ECW'(ERASE_CYC);
                        st   <= ST_ERASE;
                    end
                end
                ST_ERASE: begin
                    if (do_susp) begin
                        susp <= 1'b1;
                        st   <= ST_HOME;
                    end else begin
                        ecnt <= ecnt - ECW'(1);
                        if (ecnt == ECW'(1)) begin
                            marks <= '0;
                            st    <= ST_HOME;
                        end
                    end
                end
                ST_BEXIT: if (bw.wr) begin
                    if (cmd == C_BYP_OFF2) byp <= 1'b0;
                    st <= ST_HOME;
                end
                default: st <= ST_HOME;
            endcase
        end
    end

    // R10: reset leaves home state with bypass and suspend cleared
    a_r10_reset_home: assert property (@(posedge clk)
        rst |=> (st == ST_HOME && !byp && !susp));

    // R7: erase time remaining is frozen while suspended
    a_r7_count_frozen: assert property (@(posedge clk) disable iff (rst)
        (susp && st != ST_ERASE) |=> $stable(ecnt));

endmodule

// File: rtl/fcmd_array.sv
`timescale 1ns/1ps
module fcmd_array
    import flash_cmd_pkg::*;
#(
    parameter int UNIT = 2,
    parameter int NBIG = 3,
    localparam int NSEC  = 4 + NBIG,
    localparam int WORDS = UNIT * (8 + 8 * NBIG),
    localparam int AW    = $clog2(WORDS),
    localparam int SW    = $clog2(NSEC)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            prog_fire,
    input  logic [AW-1:0]   prog_addr,
    input  logic [15:0]     prog_data,
    input  logic            erase_fire,
    input  logic [NSEC-1:0] erase_mask,
    input  logic [NSEC-1:0] lock,
    input  logic [AW-1:0]   rd_addr,
    output logic [15:0]     rd_word
);
    logic [15:0]      mem [WORDS];
    logic [WORDS-1:0] wipe;
    logic [SW-1:0]    psec;
    logic             prog_ok;

    assign psec    = SW'(sec_of(int'(prog_addr), UNIT, NBIG));
    assign prog_ok = prog_fire && !lock[psec];

    for (genvar w = 0; w < WORDS; w++) begin : g_wipe
        localparam int SEC_W = sec_of(w, UNIT, NBIG);
        assign wipe[w] = erase_fire && erase_mask[SEC_W] && !lock[SEC_W];
    end

    always_ff @(posedge clk) begin
        if (prog_ok) mem[prog_addr] <= mem[prog_addr] & prog_data;
        for (int i = 0; i < WORDS; i++) begin
            if (wipe[i]) mem[i] <= '1;
        end
    end

    assign rd_word = mem[rd_addr];

    // R3: a program only clears bits of the target word
    a_r3_and_only: assert property (@(posedge clk) disable iff (rst)
        prog_ok |=> (mem[$past(prog_addr)] == ($past(mem[prog_addr]) & $past(prog_data))));

    // R8: a program aimed at a locked sector changes nothing
    a_r8_locked_keep: assert property (@(posedge clk) disable iff (rst)
        (prog_fire && lock[psec]) |=> (mem[$past(prog_addr)] == $past(mem[prog_addr])));

endmodule

// File: rtl/fcmd_rdport.sv
`timescale 1ns/1ps
module fcmd_rdport
    import flash_cmd_pkg::*;
#(
    parameter int UNIT = 2,
    parameter int NBIG = 3,
    localparam int NSEC  = 4 + NBIG,
    localparam int WORDS = UNIT * (8 + 8 * NBIG),
    localparam int AW    = $clog2(WORDS),
    localparam int SW    = $clog2(NSEC)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rd,
    input  logic [AW-1:0]   rd_addr,
    input  logic [15:0]     rd_word,
    input  logic            prog_busy,
    input  logic            prog_b7,
    input  logic            erase_busy,
    input  logic            susp,
    input  logic [NSEC-1:0] marks,
    output logic [15:0]     rdata
);
    logic          tog;
    logic [SW-1:0] rd_sec;

    assign rd_sec = SW'(sec_of(int'(rd_addr), UNIT, NBIG));

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            tog   <= 1'b0;
        end else if (rd) begin
            if (prog_busy) begin
                rdata <= stat_word(~prog_b7, tog);
                tog   <= ~tog;
            end else if (erase_busy) begin
                rdata <= stat_word(1'b0, tog);
                tog   <= ~tog;
            end else if (susp && marks[rd_sec]) begin
                rdata <= stat_word(1'b1, tog);
            end else begin
                rdata <= rd_word;
            end
        end
    end

    // R5: status words carry only the two flag bits
    a_r5_status_clean: assert property (@(posedge clk) disable iff (rst)
        (rd && (prog_busy || erase_busy)) |=> (rdata[15:8] == 8'h00 && rdata[5:0] == 6'h00));

endmodule

// File: rtl/flash_cmd_ctrl.sv
`timescale 1ns/1ps
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int UNIT      = 2,
    parameter int NBIG      = 3,
    parameter int PROG_CYC  = 4,
    parameter int ERASE_CYC = 20,
    parameter int WIN_CYC   = 6,
    localparam int NSEC  = 4 + NBIG,
    localparam int WORDS = UNIT * (8 + 8 * NBIG),
    localparam int AW    = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ce_n,
    input  logic            we_n,
    input  logic            oe_n,
    input  logic [10:0]     addr,
    input  logic [15:0]     wdata,
    input  logic [NSEC-1:0] lock,
    output logic [15:0]     rdata,
    output logic            ready_n
);
    bus_wr_t         bw;
    logic            rd;
    logic            prog_fire, erase_fire, prog_busy, erase_busy, susp;
    logic [AW-1:0]   prog_addr;
    logic [15:0]     prog_data, rd_word;
    logic [NSEC-1:0] marks;

    assign bw.wr   = !ce_n && !we_n;
    assign bw.addr = addr;
    assign bw.data = wdata;
    assign rd      = !ce_n && !oe_n && we_n;
    assign ready_n = !(prog_busy || erase_busy);

    fcmd_seq #(
        .UNIT(UNIT), .NBIG(NBIG), .PROG_CYC(PROG_CYC),
        .ERASE_CYC(ERASE_CYC), .WIN_CYC(WIN_CYC)
    ) u_seq (
        .clk(clk), .rst(rst), .bw(bw),
        .prog_fire(prog_fire), .prog_addr(prog_addr), .prog_data(prog_data),
        .erase_fire(erase_fire), .marks(marks),
        .prog_busy(prog_busy), .erase_busy(erase_busy), .susp(susp)
    );

    fcmd_array #(.UNIT(UNIT), .NBIG(NBIG)) u_array (
        .clk(clk), .rst(rst),
        .prog_fire(prog_fire), .prog_addr(prog_addr), .prog_data(prog_data),
        .erase_fire(erase_fire), .erase_mask(marks), .lock(lock),
        .rd_addr(addr[AW-1:0]), .rd_word(rd_word)
    );

    fcmd_rdport #(.UNIT(UNIT), .NBIG(NBIG)) u_rdport (
        .clk(clk), .rst(rst), .rd(rd), .rd_addr(addr[AW-1:0]), .rd_word(rd_word),
        .prog_busy(prog_busy), .prog_b7(prog_data[7]), .erase_busy(erase_busy),
        .susp(susp), .marks(marks), .rdata(rdata)
    );

    // R9: the ready output rises once the array is written
    a_r9_ready_after_prog: assert property (@(posedge clk) disable iff (rst)
        prog_fire |=> ready_n);

endmodule

// File: tb/flash_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_bench;
    localparam int NSEC = 7;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [10:0]     addr = '0;
    logic [15:0]     wdata = '0;
    logic [NSEC-1:0] lock = '0;
    logic [15:0]     rdata;
    logic            ready_n;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    flash_cmd_ctrl u_flash_cmd_ctrl (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .lock(lock), .rdata(rdata), .ready_n(ready_n)
    );

    always #2.5 clk = ~clk;

    typedef struct packed {
        logic [2:0]  op;
        logic [10:0] a;
        logic [15:0] d;
        logic [23:0] tag;
    } vec_t;

    localparam logic [2:0] V_I = 3'd0, V_W = 3'd1, V_R = 3'd2, V_B = 3'd3, V_C = 3'd4;

    localparam vec_t VEC [64] = '{
        '{V_C, 11'h555, 16'h0080, "R4 "},   // chip erase
        '{V_C, 11'h555, 16'h0010, "R4 "},
        '{V_R, 11'h003, 16'h0000, "R5 "},   // erase status, toggle 0
        '{V_R, 11'h003, 16'h0040, "R5 "},   // toggle 1
        '{V_I, 11'h000, 16'd30,   "   "},
        '{V_R, 11'h000, 16'hFFFF, "R4 "},
        '{V_C, 11'h555, 16'h00A0, "R1 "},   // normal program
        '{V_W, 11'h005, 16'h1234, "R1 "},
        '{V_R, 11'h005, 16'h0080, "R5 "},   // inverted bit 7
        '{V_I, 11'h000, 16'd10,   "   "},
        '{V_R, 11'h005, 16'h1234, "R1 "},
        '{V_C, 11'h555, 16'h00A0, "R3 "},   // clear-only program
        '{V_W, 11'h005, 16'hFF00, "R3 "},
        '{V_I, 11'h000, 16'd10,   "   "},
        '{V_R, 11'h005, 16'h1200, "R3 "},
        '{V_W, 11'h555, 16'h00AA, "R2 "},   // wrong second unlock address
        '{V_W, 11'h2AB, 16'h0055, "R2 "},
        '{V_W, 11'h555, 16'h00A0, "R2 "},
        '{V_W, 11'h006, 16'h0000, "R2 "},
        '{V_I, 11'h000, 16'd10,   "   "},
        '{V_R, 11'h006, 16'hFFFF, "R2 "},
        '{V_C, 11'h555, 16'h0020, "R6 "},   // bypass on
        '{V_W, 11'h000, 16'h00A0, "R6 "},
        '{V_W, 11'h007, 16'h00F0, "R6 "},
        '{V_I, 11'h000, 16'd10,   "   "},
        '{V_R, 11'h007, 16'h00F0, "R6 "},
        '{V_W, 11'h000, 16'h0090, "R6 "},   // bypass off
        '{V_W, 11'h000, 16'h0000, "R6 "},
        '{V_W, 11'h000, 16'h00A0, "R6 "},
        '{V_W, 11'h008, 16'h0000, "R6 "},
        '{V_I, 11'h000, 16'd10,   "   "},
        '{V_R, 11'h008, 16'hFFFF, "R6 "},
        '{V_C, 11'h555, 16'h00A0, "R4 "},
        '{V_W, 11'h014, 16'h0000, "R4 "},
        '{V_I, 11'h000, 16'd10,   "   "},
        '{V_C, 11'h555, 16'h0080, "R4 "},   // two-sector erase
        '{V_W, 11'h555, 16'h00AA, "R4 "},
        '{V_W, 11'h2AA, 16'h0055, "R4 "},
        '{V_W, 11'h004, 16'h0030, "R4 "},
        '{V_W, 11'h014, 16'h0030, "R4 "},
        '{V_I, 11'h000, 16'd40,   "   "},
        '{V_R, 11'h005, 16'hFFFF, "R4 "},
        '{V_R, 11'h014, 16'hFFFF, "R4 "},
        '{V_R, 11'h007, 16'h00F0, "R4 "},
        '{V_C, 11'h555, 16'h00A0, "R7 "},
        '{V_W, 11'h024, 16'h0000, "R7 "},
        '{V_I, 11'h000, 16'd10,   "   "},
        '{V_C, 11'h555, 16'h0080, "R7 "},
        '{V_W, 11'h555, 16'h00AA, "R7 "},
        '{V_W, 11'h2AA, 16'h0055, "R7 "},
        '{V_W, 11'h020, 16'h0030, "R7 "},
        '{V_I, 11'h000, 16'd9,    "   "},
        '{V_W, 11'h000, 16'h00B0, "R7 "},   // suspend
        '{V_B, 11'h000, 16'h0001, "R9 "},
        '{V_R, 11'h007, 16'h00F0, "R7 "},
        '{V_R, 11'h024, 16'h00C0, "R5 "},   // frozen toggle
        '{V_R, 11'h024, 16'h00C0, "R5 "},
        '{V_C, 11'h555, 16'h00A0, "R7 "},
        '{V_W, 11'h009, 16'h5A5A, "R7 "},
        '{V_I, 11'h000, 16'd10,   "   "},
        '{V_R, 11'h009, 16'h5A5A, "R7 "},
        '{V_W, 11'h000, 16'h0030, "R7 "},   // resume
        '{V_I, 11'h000, 16'd30,   "   "},
        '{V_R, 11'h024, 16'hFFFF, "R7 "}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [10:0] a, input logic [15:0] d);
        ce_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic bus_rd(input logic [10:0] a, input logic [15:0] exp, input string tag);
        ce_n = 1'b0; oe_n = 1'b0; addr = a;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        check(tag, rdata, exp);
    endtask

    task automatic cmd3(input logic [15:0] c);
        bus_wr(11'h555, 16'h00AA);
        bus_wr(11'h2AA, 16'h0055);
        bus_wr(11'h555, c);
    endtask

    task automatic pulse_rst();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles == 150000) begin
                fails++;
                tests++;
                $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        check("R10 reset ready", {15'h0, ready_n}, 16'h0001);
        check("R10 reset rdata", rdata, 16'h0000);

        for (int v = 0; v < 64; v++) begin
            case (VEC[v].op)
                V_I: idle(int'(VEC[v].d));
                V_W: bus_wr(VEC[v].a, VEC[v].d);
                V_R: bus_rd(VEC[v].a, VEC[v].d, $sformatf("%s vec %0d", VEC[v].tag, v));
                V_B: check($sformatf("%s vec %0d", VEC[v].tag, v), {15'h0, ready_n}, VEC[v].d);
                default: cmd3(VEC[v].d);
            endcase
        end

        // R9: ready low while a program runs, high afterwards
        cmd3(16'h00A0);
        bus_wr(11'h00A, 16'h00FF);
        check("R9 busy low", {15'h0, ready_n}, 16'h0000);
        idle(10);
        check("R9 ready high", {15'h0, ready_n}, 16'h0001);
        bus_rd(11'h00A, 16'h00FF, "R1 second word");

        // R8: locked sector 0 ignores program and erase
        cmd3(16'h00A0); bus_wr(11'h002, 16'h1234); idle(10);
        cmd3(16'h00A0); bus_wr(11'h028, 16'h0000); idle(10);
        lock = 7'b0000001;
        cmd3(16'h00A0); bus_wr(11'h001, 16'h0000); idle(10);
        bus_rd(11'h001, 16'hFFFF, "R8 program blocked");
        cmd3(16'h0080); cmd3(16'h0010); idle(30);
        bus_rd(11'h002, 16'h1234, "R8 erase blocked");
        bus_rd(11'h028, 16'hFFFF, "R4 chip erase unlocked");
        lock = '0;

        // R10: reset in the middle of a program
        cmd3(16'h00A0); bus_wr(11'h01E, 16'h0000);
        idle(1);
        pulse_rst();
        check("R10 abort ready", {15'h0, ready_n}, 16'h0001);
        idle(10);
        bus_rd(11'h01E, 16'hFFFF, "R10 abort keeps word");

        // R10: reset clears bypass
        cmd3(16'h0020);
        pulse_rst();
        bus_wr(11'h000, 16'h00A0); bus_wr(11'h01F, 16'h0000); idle(10);
        bus_rd(11'h01F, 16'hFFFF, "R10 bypass cleared");

        // R2: reset command inside a sequence
        bus_wr(11'h555, 16'h00AA); bus_wr(11'h000, 16'h00F0);
        bus_wr(11'h2AA, 16'h0055); bus_wr(11'h555, 16'h00A0);
        bus_wr(11'h01D, 16'h0000); idle(10);
        bus_rd(11'h01D, 16'hFFFF, "R2 reset command");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule